// File: doc/BRIEF.md
# Dual-Edge Watchdog Timer with Startup Window

This block watches one synchronized watchdog line and asks for a system reset when the line stops moving. A transition in either direction proves that the software is alive, and it clears the internal tick counter. If the line stays at one level for `TIMEOUT_TICKS` clock cycles, the block raises a one-cycle expiry request and starts counting again from zero.

A longer grace period, `STARTUP_TICKS`, applies when the block becomes enabled and again each time the system reset is released. This gives the software time to make its first transition. While the system reset is active, the timer is held clear. When the enable flag is low, which means the line has been found unconnected, the watchdog is switched off.

The controller is a five-state machine:

- **OFF**: disabled.
- **STARTUP**: the grace window is counting.
- **ARMED**: the normal timeout is counting.
- **FIRE**: the single expiry cycle.
- **HOLD**: the system reset is active.

The transitions are as follows:

| Name | From | To | Condition |
|---|---|---|---|
| disable | any state | OFF | `wd_en` low |
| hold | any enabled state | HOLD | `sys_rst_active` high |
| wake | OFF or HOLD | STARTUP | enabled, and `sys_rst_active` low |
| first-edge | STARTUP | ARMED | an edge is seen |
| grace-expire | STARTUP | FIRE | the counter reaches `STARTUP_TICKS-1` with no edge |
| kick | ARMED | ARMED | an edge is seen; the counter clears |
| timeout | ARMED | FIRE | the counter reaches `TIMEOUT_TICKS-1` with no edge |
| rearm | FIRE | ARMED | always; the counter is zero |

Top module: `wdt_dual_edge`

## Requirements
- R1: While `rst` is sampled high, the block goes to OFF: `expire` = 0, `in_startup` = 0, and edge history is discarded. When `rst` is low and `wd_en` is high, the following cycle enters STARTUP.
- R2: While `wd_en` is low, the block stays in OFF. `expire` and `in_startup` stay 0 whatever `wd_in` does. When `wd_en` returns high, STARTUP is entered one cycle later.
- R3: On entering STARTUP, `in_startup` is 1 for exactly `STARTUP_TICKS` cycles if no edge arrives. The expiry pulse follows in the next cycle.
- R4: After an edge is sampled at a clock edge, with no further edge, `expire` rises `TIMEOUT_TICKS` clock edges later.
- R5: A rising edge and a falling edge on `wd_in` each clear the counter. Toggling at intervals shorter than `TIMEOUT_TICKS` never produces an expiry.
- R6: An edge is found by comparing the present sample with the registered previous sample. A held level after a transition therefore counts only once, and two transitions in consecutive cycles time out from the second one.
- R7: `expire` is high for exactly one cycle. With the line still quiet, the next pulse follows `TIMEOUT_TICKS+1` cycles later, because the counter restarts from zero.
- R8: While `sys_rst_active` is high and the block is enabled, it sits in HOLD: the counter is clear, and `expire` and `in_startup` are 0. When `sys_rst_active` falls, STARTUP is entered.
- R9: An edge sampled in the same cycle that the counter reaches its limit wins: no expiry occurs, and the counter clears.
- R10: An edge during STARTUP ends the window. `in_startup` falls in the next cycle, and the normal timeout applies from that edge.
- R11: `TIMEOUT_TICKS` is at least 2, and `STARTUP_TICKS` is at least `TIMEOUT_TICKS`. Any other setting is rejected when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wd_in | input | 1 | Watchdog line, already synchronized |
| wd_en | input | 1 | High when the line is connected; low disables the watchdog |
| sys_rst_active | input | 1 | High while the system reset is asserted |
| expire | output | 1 | One-cycle reset request |
| in_startup | output | 1 | High while the startup window is counting |

## Verification
The bench measures, from the moment of release and from each edge, how many cycles pass before the expiry pulse. A counter that is off by one, or that starts at the wrong value, changes these distances by one cycle. The bench toggles the line in the very cycle the counter reaches its limit. A design that lets the limit win over the edge emits a false pulse there. The bench also places two edges back to back, so a detector that drops or double-counts one of them shifts the pulse. Finally, it releases the system reset and raises the enable flag mid-stream and checks that the long window follows. A design that skips the re-entry times out after the short period instead.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        WD_OFF     = 3'd0,
        WD_STARTUP = 3'd1,
        WD_ARMED   = 3'd2,
        WD_FIRE    = 3'd3,
        WD_HOLD    = 3'd4
    } wd_state_t;

endpackage

// File: rtl/wdt_edge_detect.sv
module wdt_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic wd_in,
    output logic edge_seen
);

    logic prev_q;
    logic primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= wd_in;
            primed_q <= 1'b1;
        end
    end

    // Any level change against the stored sample, in either direction
    assign edge_seen = primed_q && (wd_in ^ prev_q);

    // R6
    edge_once_chk: assert property (@(posedge clk) disable iff (rst)
        (primed_q && (wd_in == $past(wd_in))) |-> !edge_seen);

    // R5
    edge_found_chk: assert property (@(posedge clk) disable iff (rst)
        (primed_q && (wd_in != $past(wd_in))) |-> edge_seen);

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |-> (cnt != {CW{1'b1}}));

endmodule

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1000,
    parameter int STARTUP_TICKS = 50000,
    parameter int CW            = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wd_en,
    input  logic          sys_rst_active,
    input  logic          edge_seen,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          expire,
    output logic          in_startup
);

    localparam logic [CW-1:0] T_LAST = CW'(TIMEOUT_TICKS - 1);
    localparam logic [CW-1:0] S_LAST = CW'(STARTUP_TICKS - 1);

    wd_state_t state_q;
    wd_state_t state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state: disable beats hold, hold beats counting
    always_comb begin
        state_nx = state_q;
        if (!wd_en) begin
            state_nx = WD_OFF;
        end else if (sys_rst_active) begin
            state_nx = WD_HOLD;
        end else begin
            unique case (state_q)
                WD_OFF, WD_HOLD: state_nx = WD_STARTUP;
                WD_STARTUP: begin
                    if (edge_seen) begin
                        state_nx = WD_ARMED;
                    end else if (cnt == S_LAST) begin
                        state_nx = WD_FIRE;
                    end
                end
                WD_ARMED: begin
                    if (!edge_seen && cnt == T_LAST) begin
                        state_nx = WD_FIRE;
                    end
                end
                WD_FIRE: state_nx = WD_ARMED;
                default: state_nx = WD_OFF;
            endcase
        end
    end

    // Outputs and counter control
    always_comb begin
        expire     = (state_q == WD_FIRE);
        in_startup = (state_q == WD_STARTUP);
        cnt_clr    = (state_nx != state_q)
                  || (state_q == WD_ARMED && edge_seen)
                  || (state_q == WD_OFF)
                  || (state_q == WD_HOLD)
                  || (state_q == WD_FIRE);
        cnt_inc    = !cnt_clr
                  && (state_q == WD_STARTUP || state_q == WD_ARMED);
    end

    // R7
    expire_single_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> (!expire && !in_startup));

    // R8
    hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_en && sys_rst_active) |=> (!expire && !in_startup && cnt == '0));

    // R9
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_ARMED && edge_seen && wd_en && !sys_rst_active) |=> !expire);

    // R10
    startup_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_startup && edge_seen && wd_en && !sys_rst_active) |=> (!in_startup && cnt == '0));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= S_LAST);

endmodule

// File: rtl/wdt_dual_edge.sv
module wdt_dual_edge #(
    parameter int TIMEOUT_TICKS = 1000,
    parameter int STARTUP_TICKS = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic wd_in,
    input  logic wd_en,
    input  logic sys_rst_active,
    output logic expire,
    output logic in_startup
);

    localparam int CW = $clog2(STARTUP_TICKS + 1);

    // R11
    generate
        if (TIMEOUT_TICKS < 2 || STARTUP_TICKS < TIMEOUT_TICKS) begin : g_bad_cfg
            $error("wdt_dual_edge: need 2 <= TIMEOUT_TICKS <= STARTUP_TICKS");
        end
    endgenerate

    logic          edge_seen;
    logic          cnt_clr;
    logic          cnt_inc;
    logic [CW-1:0] cnt;

    wdt_edge_detect u_edge (
        .clk       (clk),
        .rst       (rst),
        .wd_in     (wd_in),
        .edge_seen (edge_seen)
    );

    wdt_tick_counter #(.CW(CW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .cnt (cnt)
    );

    wdt_ctrl_fsm #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS),
        .STARTUP_TICKS (STARTUP_TICKS),
        .CW            (CW)
    ) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .wd_en          (wd_en),
        .sys_rst_active (sys_rst_active),
        .edge_seen      (edge_seen),
        .cnt            (cnt),
        .cnt_clr        (cnt_clr),
        .cnt_inc        (cnt_inc),
        .expire         (expire),
        .in_startup     (in_startup)
    );

endmodule

// File: tb/wdt_dual_edge_test.sv
`timescale 1ns/1ps
module wdt_dual_edge_test;

    localparam int T = 16;
    localparam int S = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wd_in = 1'b0;
    logic wd_en = 1'b1;
    logic sys_rst_active = 1'b0;
    logic expire;
    logic in_startup;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    wdt_dual_edge #(.TIMEOUT_TICKS(T), .STARTUP_TICKS(S)) uut (
        .clk            (clk),
        .rst            (rst),
        .wd_in          (wd_in),
        .wd_en          (wd_en),
        .sys_rst_active (sys_rst_active),
        .expire         (expire),
        .in_startup     (in_startup)
    );

    // Reference model: 0 off, 1 startup, 2 armed, 3 fire, 4 hold
    int m_st = 0;
    int m_cnt = 0;
    bit m_prev = 1'b0;
    bit m_primed = 1'b0;

    function automatic int next_state(int st, int cnt, bit edge_now, bit en, bit hold);
        if (!en) return 0;
        if (hold) return 4;
        case (st)
            0, 4: return 1;
            1: begin
                if (edge_now) return 2;
                if (cnt == S - 1) return 3;
                return 1;
            end
            2: return (!edge_now && cnt == T - 1) ? 3 : 2;
            default: return 2;
        endcase
    endfunction

    always @(posedge clk) begin
        bit e;
        int nx;
        e = m_primed && (wd_in != m_prev);
        if (rst) begin
            m_st = 0; m_cnt = 0; m_prev = 1'b0; m_primed = 1'b0;
        end else begin
            nx = next_state(m_st, m_cnt, e, wd_en, sys_rst_active);
            if (nx != m_st || (m_st == 2 && e) || m_st == 0 || m_st == 3 || m_st == 4)
                m_cnt = 0;
            else
                m_cnt = m_cnt + 1;
            m_st = nx;
            m_prev = wd_in;
            m_primed = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk(expire === (m_st == 3), cur_req, "expire vs model", int'(expire), int'(m_st == 3));
        chk(in_startup === (m_st == 1), cur_req, "in_startup vs model", int'(in_startup), int'(m_st == 1));
    endtask

    task automatic wait_exp(input int maxn, output int n, output int n_st);
        n = 0; n_st = 0;
        while (n < maxn) begin
            tick();
            n++;
            if (expire === 1'b1) break;
            if (in_startup === 1'b1) n_st++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n, ns;
        bit seen;
        void'($urandom(32'd4242));

        // R1 reset state
        cur_req = "R1";
        repeat (3) tick();
        chk(expire == 1'b0, "R1", "expire in reset", int'(expire), 0);
        chk(in_startup == 1'b0, "R1", "in_startup in reset", int'(in_startup), 0);
        rst = 1'b0;

        // R3 startup window length
        cur_req = "R3";
        wait_exp(S + 10, n, ns);
        chk(n == S + 1, "R3", "samples to startup expiry", n, S + 1);
        chk(ns == S, "R3", "startup samples", ns, S);

        // R7 single pulse and restart
        cur_req = "R7";
        wait_exp(T + 10, n, ns);
        chk(n == T + 1, "R7", "pulse spacing", n, T + 1);
        tick();
        chk(expire == 1'b0, "R7", "pulse width", int'(expire), 0);

        // R4/R5 rising edge
        cur_req = "R5";
        wd_in = 1'b1;
        wait_exp(T + 10, n, ns);
        chk(n == T + 1, "R4", "timeout after rising edge", n, T + 1);
        // R5 falling edge
        wd_in = 1'b0;
        wait_exp(T + 10, n, ns);
        chk(n == T + 1, "R5", "timeout after falling edge", n, T + 1);

        // R6 back-to-back transitions
        cur_req = "R6";
        wd_in = 1'b1; tick();
        wd_in = 1'b0;
        wait_exp(T + 10, n, ns);
        chk(n == T + 1, "R6", "timeout from second edge", n, T + 1);

        // R5 steady kicking keeps it quiet
        cur_req = "R5";
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            wd_in = ~wd_in;
            repeat (T - 1) begin tick(); if (expire) seen = 1'b1; end
        end
        chk(!seen, "R5", "expiry while kicked", int'(seen), 0);

        // R9 edge at the limit
        cur_req = "R9";
        wd_in = ~wd_in;
        seen = 1'b0;
        repeat (T) begin tick(); if (expire) seen = 1'b1; end
        wd_in = ~wd_in;
        wait_exp(T + 10, n, ns);
        chk(!seen, "R9", "early expiry", int'(seen), 0);
        chk(n == T + 1, "R9", "edge at limit clears", n, T + 1);

        // R8 hold then re-entry, R10 edge during startup
        cur_req = "R8";
        sys_rst_active = 1'b1;
        repeat (5) tick();
        chk(expire == 1'b0 && in_startup == 1'b0, "R8", "quiet in hold", int'(in_startup), 0);
        sys_rst_active = 1'b0;
        tick();
        chk(in_startup == 1'b1, "R8", "startup after hold", int'(in_startup), 1);
        cur_req = "R10";
        repeat (10) tick();
        wd_in = ~wd_in;
        tick();
        chk(in_startup == 1'b0, "R10", "startup ends on edge", int'(in_startup), 0);
        wait_exp(T + 10, n, ns);
        chk(n == T, "R10", "normal timeout after startup edge", n, T);

        // R8 hold near trip, then full window
        cur_req = "R8";
        wd_in = ~wd_in;
        repeat (T - 2) tick();
        sys_rst_active = 1'b1;
        seen = 1'b0;
        repeat (T + 5) begin tick(); if (expire) seen = 1'b1; end
        chk(!seen, "R8", "no expiry in hold", int'(seen), 0);
        sys_rst_active = 1'b0;
        wait_exp(S + 10, n, ns);
        chk(n == S + 1, "R8", "full window after hold", n, S + 1);

        // R2 disabled
        cur_req = "R2";
        wd_en = 1'b0;
        seen = 1'b0;
        repeat (3 * S) begin tick(); if (expire || in_startup) seen = 1'b1; end
        chk(!seen, "R2", "activity while disabled", int'(seen), 0);
        wd_en = 1'b1;
        tick();
        chk(in_startup == 1'b1, "R2", "startup on enable", int'(in_startup), 1);

        // Random mix, checked against the model (R4 family)
        cur_req = "R4";
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 11) == 0) wd_in = ~wd_in;
            if ($urandom_range(0, 299) == 0) sys_rst_active = 1'b1;
            else if ($urandom_range(0, 7) == 0) sys_rst_active = 1'b0;
            if ($urandom_range(0, 499) == 0) wd_en = ~wd_en;
            else if (!wd_en && $urandom_range(0, 19) == 0) wd_en = 1'b1;
            rst = ($urandom_range(0, 1999) == 0);
            tick();
        end
        rst = 1'b0;
        tick();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule